// File: doc/BRIEF.md
# Output Power-Good and Fault Supervisor

This block sits beside the control loop of a step-down memory supply. It reads window comparator flags from the regulated output, already digitized, and a thermal trip flag. From them it produces a filtered power-good output, a request to hold the low-side switch on, a request to turn all switches off, and a single latched-fault flag. Analog sensing is not part of the block.

Power-good has hysteresis. It rises only after soft-start has finished and the output has passed 93% of its set point. It then stays high while the output remains between 90% and 115%. Every change of power-good must persist for a parameterized number of clock cycles before it reaches the pin.

Faults are handled as follows:
- Over-voltage pulls the low side on at once. It latches if it persists for a parameterized delay.
- Under-voltage is ignored during a parameterized blanking window after enable. After that window it latches an all-off shutdown.
- A thermal trip latches an all-off shutdown on the next clock edge.

All latches clear when the converter is disabled, meaning the sleep-state enable is low or the supply power-on flag is low.

Top module: `pgs_supervisor`

## Requirements
- R1: After reset, pgood, force_ls, force_off and fault_latched are all 0.
- R2: pgood rises only when all of the following hold for PG_DLY_CYC consecutive clock cycles: supply_ok=1, s5_en=1, ss_done=1, cmp_rdy=1, cmp_hi=0, cmp_lo=0, and no fault latched. While ss_done=0, pgood stays 0.
- R3: Once high, pgood stays high while cmp_hi=0 and cmp_lo=0, even if cmp_rdy falls. It falls after PG_DLY_CYC consecutive cycles with cmp_hi=1 or cmp_lo=1. When it is low, returning inside the window without cmp_rdy=1 does not raise it.
- R4: A disturbance on cmp_hi that lasts fewer than PG_DLY_CYC cycles leaves pgood unchanged.
- R5: While enabled, cmp_ov=1 drives force_ls=1 in the same cycle, combinationally, unless force_off=1.
- R6: Over-voltage latches after OV_DLY_CYC consecutive cycles of cmp_ov=1. It then sets fault_latched=1 and holds force_ls=1 after cmp_ov falls. A shorter burst latches nothing.
- R7: cmp_uv is ignored for the first UV_BLANK_CYC clock edges after enable. After that window, cmp_uv=1 latches force_off=1 and fault_latched=1 on the next edge.
- R8: When cmp_ov=1 and cmp_uv=1 together, the under-voltage latch is not set, so over-voltage handling wins.
- R9: therm_trip=1 while enabled latches force_off=1 on the next edge, and force_off overrides force_ls. therm_trip is ignored while disabled.
- R10: Any latched fault keeps pgood low. The edge after s5_en=0 or supply_ok=0 clears all latches.
- R11: force_ls and force_off are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply power-on flag, 1 = supply valid |
| s5_en | input | 1 | Sleep-state enable, 1 = converter on |
| ss_done | input | 1 | Soft-start finished |
| cmp_ov | input | 1 | Output above 116% |
| cmp_uv | input | 1 | Output below 70% |
| cmp_hi | input | 1 | Output above 115% |
| cmp_lo | input | 1 | Output below 90% |
| cmp_rdy | input | 1 | Output above 93% |
| therm_trip | input | 1 | Die over-temperature |
| pgood | output | 1 | Power-good, 1 = good, open-drain released |
| force_ls | output | 1 | Request to hold the low-side switch on |
| force_off | output | 1 | Request to turn all switches off |
| fault_latched | output | 1 | A fault latch is set |

## Verification
A counter that is off by one cycle moves the pgood edge, the over-voltage latch edge or the end of blanking by exactly one clock. Each of these is visible on a port in the cycle where the delay ends. A lost hysteresis state appears as pgood rising again between 90% and 93%, or falling there. A wrong latch or a wrong priority shows up within one edge of the stimulus: force_off appears when it should not, force_ls and force_off are both asserted, or a fault survives a disable.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef struct packed {
    logic ov;
    logic uv;
    logic ot;
  } pgs_latch_t;

  localparam pgs_latch_t PGS_LATCH_CLR = '{ov: 1'b0, uv: 1'b0, ot: 1'b0};
endpackage

// File: rtl/pgs_streak.sv
module pgs_streak #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic hit
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign hit = cond && (cnt_q == LAST);

  always_comb begin
    if (!cond || hit) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pgs_blank.sv
module pgs_blank #(
  parameter int SPAN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = $clog2(SPAN + 1);
  localparam logic [W-1:0] END_VAL = W'(SPAN);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign done   = (cnt_q == END_VAL);
  assign cnt_en = !run || !done;

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pgs_fault_ctl.sv
module pgs_fault_ctl
  import pgs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cmp_ov,
  input  logic ov_hit,
  input  logic uv_req,
  input  logic ot_req,
  output logic force_ls,
  output logic force_off,
  output logic fault_any
);
  pgs_latch_t lat_q, lat_d;

  always_comb begin
    if (!en) begin
      lat_d = PGS_LATCH_CLR;
    end else begin
      lat_d = lat_q;
      if (ot_req)           lat_d.ot = 1'b1;
      if (ov_hit)           lat_d.ov = 1'b1;
      if (uv_req && !cmp_ov) lat_d.uv = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= PGS_LATCH_CLR;
    else        lat_q <= lat_d;
  end

  assign force_off = lat_q.ot | lat_q.uv;
  assign force_ls  = !force_off && (lat_q.ov || (en && cmp_ov));
  assign fault_any = lat_q.ov | lat_q.uv | lat_q.ot;
endmodule

// File: rtl/pgs_supervisor.sv
module pgs_supervisor #(
  parameter int PG_DLY_CYC   = 313,
  parameter int OV_DLY_CYC   = 625,
  parameter int UV_BLANK_CYC = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic s5_en,
  input  logic ss_done,
  input  logic cmp_ov,
  input  logic cmp_uv,
  input  logic cmp_hi,
  input  logic cmp_lo,
  input  logic cmp_rdy,
  input  logic therm_trip,
  output logic pgood,
  output logic force_ls,
  output logic force_off,
  output logic fault_latched
);
  logic en, uv_armed, ov_hit, fault_any;
  logic pg_q, pg_d, pg_raw, pg_hit;

  assign en = supply_ok & s5_en;

  pgs_blank #(.SPAN(UV_BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .run(en), .done(uv_armed)
  );

  pgs_streak #(.LIMIT(OV_DLY_CYC)) u_ov_dly (
    .clk(clk), .rst_n(rst_n), .cond(en & cmp_ov), .hit(ov_hit)
  );

  pgs_fault_ctl u_fault (
    .clk(clk), .rst_n(rst_n), .en(en), .cmp_ov(cmp_ov),
    .ov_hit(ov_hit), .uv_req(en & uv_armed & cmp_uv),
    .ot_req(en & therm_trip),
    .force_ls(force_ls), .force_off(force_off), .fault_any(fault_any)
  );

  // window with hysteresis: entry needs the 93% flag, holding needs only 90..115
  assign pg_raw = en && ss_done && !fault_any && !cmp_hi && !cmp_lo
                  && (cmp_rdy || pg_q);

  pgs_streak #(.LIMIT(PG_DLY_CYC)) u_pg_dly (
    .clk(clk), .rst_n(rst_n), .cond(pg_raw ^ pg_q), .hit(pg_hit)
  );

  always_comb begin
    pg_d = pg_hit ? pg_raw : pg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_q <= 1'b0;
    else        pg_q <= pg_d;
  end

  assign pgood         = pg_q;
  assign fault_latched = fault_any;
endmodule

// File: rtl/pgs_supervisor_chk.sv
module pgs_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic s5_en,
  input logic ss_done,
  input logic cmp_ov,
  input logic cmp_uv,
  input logic cmp_hi,
  input logic cmp_lo,
  input logic cmp_rdy,
  input logic therm_trip,
  input logic pgood,
  input logic force_ls,
  input logic force_off,
  input logic fault_latched
);
  p_excl_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_ls && force_off));

  p_pg_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> $past(supply_ok && s5_en && ss_done && cmp_rdy && !cmp_hi && !cmp_lo));

  p_ov_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && s5_en && cmp_ov && !force_off) |-> force_ls);

  p_therm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && s5_en && therm_trip) |=> force_off);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok || !s5_en) |=> !fault_latched);

  p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> (force_ls || force_off));

  p_ov_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && s5_en && cmp_ov && cmp_uv && !therm_trip && !force_off) |=> !force_off);
endmodule

bind pgs_supervisor pgs_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .s5_en(s5_en),
  .ss_done(ss_done), .cmp_ov(cmp_ov), .cmp_uv(cmp_uv), .cmp_hi(cmp_hi),
  .cmp_lo(cmp_lo), .cmp_rdy(cmp_rdy), .therm_trip(therm_trip),
  .pgood(pgood), .force_ls(force_ls), .force_off(force_off),
  .fault_latched(fault_latched)
);

// File: tb/pgs_supervisor_bench.sv
`timescale 1ns/1ps
module pgs_supervisor_bench;
  localparam int PG = 4;
  localparam int OV = 6;
  localparam int BL = 20;

  logic clk = 1'b0;
  logic rst_n, supply_ok, s5_en, ss_done;
  logic cmp_ov, cmp_uv, cmp_hi, cmp_lo, cmp_rdy, therm_trip;
  logic pgood, force_ls, force_off, fault_latched;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pgs_supervisor #(.PG_DLY_CYC(PG), .OV_DLY_CYC(OV), .UV_BLANK_CYC(BL)) u_pgs_supervisor (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .s5_en(s5_en),
    .ss_done(ss_done), .cmp_ov(cmp_ov), .cmp_uv(cmp_uv), .cmp_hi(cmp_hi),
    .cmp_lo(cmp_lo), .cmp_rdy(cmp_rdy), .therm_trip(therm_trip),
    .pgood(pgood), .force_ls(force_ls), .force_off(force_off),
    .fault_latched(fault_latched)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b1; s5_en = 1'b0; ss_done = 1'b0;
    cmp_ov = 0; cmp_uv = 0; cmp_hi = 0; cmp_lo = 0; cmp_rdy = 0; therm_trip = 0;
    step(2);
    chk("R1 pgood", pgood, 1'b0);
    chk("R1 force_ls", force_ls, 1'b0);
    chk("R1 force_off", force_off, 1'b0);
    chk("R1 fault", fault_latched, 1'b0);
    rst_n = 1'b1;
    step(1);

    // R2: enable, soft-start pending
    s5_en = 1'b1; cmp_rdy = 1'b1;
    step(10);
    chk("R2 held by soft-start", pgood, 1'b0);
    ss_done = 1'b1;
    step(PG - 1);
    chk("R2 before delay", pgood, 1'b0);
    step(1);
    chk("R2 after delay", pgood, 1'b1);

    // R3: hysteresis
    cmp_rdy = 1'b0;
    step(PG + 2);
    chk("R3 holds between 90 and 93", pgood, 1'b1);
    cmp_lo = 1'b1;
    step(PG - 1);
    chk("R3 low not yet filtered", pgood, 1'b1);
    step(1);
    chk("R3 falls below 90", pgood, 1'b0);
    cmp_lo = 1'b0;
    step(PG + 2);
    chk("R3 no rise without 93", pgood, 1'b0);
    cmp_rdy = 1'b1;
    step(PG);
    chk("R3 rises at 93", pgood, 1'b1);

    // R4: glitch sweep on the high flag
    for (int len = 1; len <= PG; len++) begin
      cmp_hi = 1'b1;
      step(len);
      cmp_hi = 1'b0;
      chk("R4 glitch length", pgood, (len >= PG) ? 1'b0 : 1'b1);
      step(PG);
      chk("R4 recovered", pgood, 1'b1);
    end

    // R5/R6: over-voltage burst sweep
    for (int len = 1; len < OV; len++) begin
      cmp_ov = 1'b1;
      #1;
      chk("R5 immediate low side", force_ls, 1'b1);
      step(len);
      cmp_ov = 1'b0;
      #1;
      chk("R6 short burst releases", force_ls, 1'b0);
      chk("R6 short burst no latch", fault_latched, 1'b0);
      step(1);
    end
    cmp_ov = 1'b1;
    step(OV);
    chk("R6 latched", fault_latched, 1'b1);
    cmp_ov = 1'b0;
    #1;
    chk("R6 low side held", force_ls, 1'b1);
    chk("R11 no off with ov", force_off, 1'b0);
    step(PG);
    chk("R10 pgood low on fault", pgood, 1'b0);
    s5_en = 1'b0;
    step(1);
    chk("R10 s5 clears", fault_latched, 1'b0);
    chk("R10 low side released", force_ls, 1'b0);

    // R7: under-voltage blanking
    cmp_uv = 1'b1; cmp_lo = 1'b1; cmp_rdy = 1'b0;
    s5_en = 1'b1;
    step(BL);
    chk("R7 blanked", force_off, 1'b0);
    step(1);
    chk("R7 uv latched off", force_off, 1'b1);
    chk("R7 fault", fault_latched, 1'b1);
    s5_en = 1'b0;
    step(1);
    chk("R10 cleared uv", fault_latched, 1'b0);

    // R8: ov and uv together
    cmp_ov = 1'b1;
    s5_en = 1'b1;
    step(BL + 2);
    chk("R8 no uv latch", force_off, 1'b0);
    chk("R8 low side", force_ls, 1'b1);
    cmp_ov = 1'b0;
    step(1);
    chk("R8 uv after ov drops", force_off, 1'b1);
    chk("R11 exclusive", force_ls, 1'b0);
    supply_ok = 1'b0;
    step(1);
    chk("R10 supply clears", fault_latched, 1'b0);
    supply_ok = 1'b1; s5_en = 1'b0;
    cmp_uv = 1'b0; cmp_lo = 1'b0; cmp_rdy = 1'b1;
    step(1);

    // R9: thermal
    therm_trip = 1'b1;
    step(2);
    chk("R9 ignored disabled", force_off, 1'b0);
    therm_trip = 1'b0;
    s5_en = 1'b1; cmp_ov = 1'b1;
    step(1);
    therm_trip = 1'b1;
    step(1);
    chk("R9 thermal off", force_off, 1'b1);
    chk("R9 overrides low side", force_ls, 1'b0);
    therm_trip = 1'b0; cmp_ov = 1'b0;
    step(3);
    chk("R9 stays latched", force_off, 1'b1);
    s5_en = 1'b0;
    step(1);
    chk("R10 thermal cleared", force_off, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule